// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block times the marks and spaces of a demodulated infrared envelope. The raw line is first synchronised. A programmable low-pass filter then removes pulses shorter than a minimum number of clock cycles. A reloadable divider advances a pulse-width counter (`PW_W` bits, 18 by default). Each selected edge of the filtered line closes the running measurement and starts the next one. Each closed measurement becomes one word in an 8-entry receive FIFO. The word carries the readable upper part of the count and the level of the pulse that just ended.

Software configures and drains the block through a simple read/write register port with word addresses. These are 0 control, 1 divider reload, 2 filter count, 3 status (read-only), 4 interrupt enables and 5 FIFO data (a read pops one word). Four conditions are reported: a timer timeout, a FIFO overrun, a busy receiver and a service request. A single interrupt line combines them with their enables. Timeout and overrun are sticky. They are cleared by taking the receiver enable or the FIFO enable low, not by writing to the status register.

Top module: `irpw_capture`

## Requirements
- R1: After reset the control, status and interrupt-enable registers read 0, `irq` is 0 and a read of the FIFO register returns 0.
- R2: A divider reloaded with value R advances the pulse-width counter once every R+1 cycles. When a selected edge closes a measurement, the FIFO word carries counter bits [PW_W-1:2] in bits 15:0, the line level just before the edge in bit 16, and bit 17 = 1 (valid) when read. For two edges D cycles apart, bits 15:0 equal floor((D-1)/(R+1)) >> 2.
- R3: The first selected edge after the receiver is enabled (control bit 0) only starts timing and pushes nothing. While a measurement runs, status bit 2 (busy) is 1.
- R4: Control bits 3:2 select the timing edges: 0 = none, 1 = falling, 2 = rising, 3 = both. Edges that are not selected neither push nor restart the timer.
- R5: A pulse held for fewer cycles than the filter count (register 2) is rejected and produces no edge. A count of 0 passes every level change.
- R6: If the counter would wrap before an edge arrives, status bit 0 (timeout) sets, busy drops to 0 and a marker word with bits 16:0 all ones is pushed.
- R7: With control bit 5 set, a timeout sets the status but pushes no marker word.
- R8: Timeout stays set while the receiver enable stays 1, and clears only while that enable is 0.
- R9: The FIFO holds 8 words. A push into a full FIFO is dropped and sets status bit 1 (overrun). Overrun clears only while control bit 1 (FIFO enable) is 0, and that also empties the FIFO.
- R10: Status bit 4 (service request) is set when the FIFO holds at least 4 words if control bit 4 is 0, and when it holds at least 1 word if control bit 4 is 1.
- R11: A read of the FIFO register while the FIFO is empty returns bit 17 = 0 and removes nothing.
- R12: `irq` is the OR of timeout AND enable bit 0, overrun AND enable bit 1, and service request AND enable bit 4 (register 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_in | input | 1 | Demodulated infrared envelope, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the FIFO at address 5 |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. The FIFO fill never exceeds its depth. Overrun only rises from a full FIFO, and both sticky flags hold while their enables stay high. Busy is low when the timeout flag rises. An empty FIFO read never shows a valid bit. The bench scenarios are needed for behaviour that depends on stimulus and arithmetic. That covers the count values for given pulse lengths and divider settings, the level bit, the edge-select and filter rejections, the watermark thresholds, marker suppression and the clearing of the flags by toggling the enables.

// File: rtl/irpw_pkg.sv
package irpw_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_DIV  = 3'd1;
  localparam logic [REG_AW-1:0] A_FILT = 3'd2;
  localparam logic [REG_AW-1:0] A_STAT = 3'd3;
  localparam logic [REG_AW-1:0] A_IEN  = 3'd4;
  localparam logic [REG_AW-1:0] A_FIFO = 3'd5;

  // control field positions
  localparam int C_RXEN   = 0;
  localparam int C_FEN    = 1;
  localparam int C_EDGE   = 2;
  localparam int C_WM     = 4;
  localparam int C_NOMARK = 5;
  localparam int CTRL_W   = 6;

  // status / enable bit positions
  localparam int ST_TO   = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_SREQ = 4;

  // FIFO word layout
  localparam int CNT_FW  = 16;
  localparam int LVL_BIT = 16;
  localparam int VLD_BIT = 17;
  localparam int WORD_W  = CNT_FW + 1;
  localparam logic [WORD_W-1:0] MARKER = '1;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;
endpackage

// File: rtl/irpw_rst_sync.sv
module irpw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/irpw_glitch_filter.sv
module irpw_glitch_filter #(
  parameter int FILT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_in,
  input  logic [FILT_W-1:0] min_cnt,
  output logic              level
);
  localparam logic [FILT_W:0] ONE = 1;

  logic              s1_q, s2_q, lvl_q, lvl_d;
  logic [FILT_W-1:0] cnt_q, cnt_d;
  logic [FILT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + ONE;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (s2_q != lvl_q) begin
      if (cnt_inc >= {1'b0, min_cnt}) begin
        lvl_d = s2_q;
      end else begin
        cnt_d = cnt_inc[FILT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= raw_in;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/irpw_timer.sv
module irpw_timer
  import irpw_pkg::*;
#(
  parameter int PW_W  = 18,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        edge_sel,
  input  logic              lvl,
  input  logic [DIV_W-1:0]  reload,
  input  logic              no_marker,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic              timeout,
  output logic              busy
);
  localparam int CW = PW_W - 2;
  localparam logic [PW_W-1:0]  PW_ONE  = 1;
  localparam logic [DIV_W-1:0] DIV_ONE = 1;

  logic             lvl_q, run_q, run_d, to_q, to_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [PW_W-1:0]  pw_q, pw_d;
  logic [CNT_FW-1:0] cnt_field;
  logic             rise, fall, hit;

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
  assign hit  = (rise && (edge_sel == EDGE_RISE || edge_sel == EDGE_ANY)) ||
                (fall && (edge_sel == EDGE_FALL || edge_sel == EDGE_ANY));

  always_comb begin
    cnt_field = '0;
    cnt_field[CW-1:0] = pw_q[PW_W-1:2];
    run_d     = run_q;
    to_d      = to_q;
    div_d     = div_q;
    pw_d      = pw_q;
    push      = 1'b0;
    push_data = '0;
    if (!enable) begin
      run_d = 1'b0;
      to_d  = 1'b0;
      div_d = reload;
      pw_d  = '0;
    end else if (hit) begin
      if (run_q) begin
        push      = 1'b1;
        push_data = {lvl_q, cnt_field};
      end
      run_d = 1'b1;
      pw_d  = '0;
      div_d = reload;
    end else if (run_q) begin
      if (div_q == '0) begin
        div_d = reload;
        if (pw_q == '1) begin
          to_d  = 1'b1;
          run_d = 1'b0;
          pw_d  = '0;
          if (!no_marker) begin
            push      = 1'b1;
            push_data = MARKER;
          end
        end else begin
          pw_d = pw_q + PW_ONE;
        end
      end else begin
        div_d = div_q - DIV_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= 1'b0;
      to_q  <= 1'b0;
      div_q <= '0;
      pw_q  <= '0;
    end else begin
      lvl_q <= lvl;
      run_q <= run_d;
      to_q  <= to_d;
      div_q <= div_d;
      pw_q  <= pw_d;
    end
  end

  assign timeout = to_q;
  assign busy    = run_q;
endmodule

// File: rtl/irpw_fifo.sv
module irpw_fifo #(
  parameter int W      = 17,
  parameter int DEPTH  = 8,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [W-1:0]      wdata,
  input  logic              pop,
  output logic [W-1:0]      rdata,
  output logic [FILL_W-1:0] fill,
  output logic              empty,
  output logic              drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]     LAST = AW'(DEPTH - 1);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);
  localparam logic [FILL_W-1:0] F1   = 1;
  localparam logic [AW-1:0]     A1   = 1;

  logic [W-1:0]      mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              full, do_push, do_pop;

  assign full    = (fill_q == FULL);
  assign empty   = (fill_q == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    fill_d = fill_q;
    if (flush) begin
      wp_d   = '0;
      rp_d   = '0;
      fill_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + A1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + A1;
      if (do_push && !do_pop)      fill_d = fill_q + F1;
      else if (do_pop && !do_push) fill_d = fill_q - F1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign fill  = fill_q;
endmodule

// File: rtl/irpw_capture.sv
module irpw_capture
  import irpw_pkg::*;
#(
  parameter int PW_W   = 18,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 16,
  parameter int FILT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [FILL_W-1:0] HALF = FILL_W'(DEPTH / 2);

  logic              rst_n_i;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [FILT_W-1:0] filt_q, filt_d;
  logic [2:0]        ien_q, ien_d;
  logic              ovr_q, ovr_d;
  logic              rx_en, fifo_en, flt_lvl;
  logic              tm_push, tm_timeout, tm_busy;
  logic [WORD_W-1:0] tm_data, fifo_rdata;
  logic [FILL_W-1:0] fifo_fill;
  logic              fifo_empty, fifo_drop, fifo_pop, sreq;
  logic              unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata};
  assign rx_en   = ctrl_q[C_RXEN];
  assign fifo_en = ctrl_q[C_FEN];

  irpw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  irpw_glitch_filter #(.FILT_W(FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_n_i), .raw_in(ir_in), .min_cnt(filt_q), .level(flt_lvl)
  );

  irpw_timer #(.PW_W(PW_W), .DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .enable(rx_en),
    .edge_sel(ctrl_q[C_EDGE+1:C_EDGE]), .lvl(flt_lvl), .reload(div_q),
    .no_marker(ctrl_q[C_NOMARK]), .push(tm_push), .push_data(tm_data),
    .timeout(tm_timeout), .busy(tm_busy)
  );

  assign fifo_pop = bus_rd && (bus_addr == A_FIFO) && !fifo_empty;

  irpw_fifo #(.W(WORD_W), .DEPTH(DEPTH), .FILL_W(FILL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n_i), .flush(!fifo_en), .push(tm_push && fifo_en),
    .wdata(tm_data), .pop(fifo_pop), .rdata(fifo_rdata), .fill(fifo_fill),
    .empty(fifo_empty), .drop(fifo_drop)
  );

  assign sreq = ctrl_q[C_WM] ? !fifo_empty : (fifo_fill >= HALF);

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    filt_d = filt_q;
    ien_d  = ien_q;
    if (bus_wr) begin
      case (bus_addr)
        A_CTRL: ctrl_d = bus_wdata[CTRL_W-1:0];
        A_DIV:  div_d  = bus_wdata[DIV_W-1:0];
        A_FILT: filt_d = bus_wdata[FILT_W-1:0];
        A_IEN:  ien_d  = {bus_wdata[ST_SREQ], bus_wdata[ST_OVR], bus_wdata[ST_TO]};
        default: ;
      endcase
    end
    ovr_d = fifo_en ? (ovr_q | fifo_drop) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q <= '0;
      div_q  <= '0;
      filt_q <= '0;
      ien_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      filt_q <= filt_d;
      ien_q  <= ien_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = 32'(ctrl_q);
      A_DIV:  bus_rdata = 32'(div_q);
      A_FILT: bus_rdata = 32'(filt_q);
      A_STAT: begin
        bus_rdata[ST_TO]   = tm_timeout;
        bus_rdata[ST_OVR]  = ovr_q;
        bus_rdata[ST_BUSY] = tm_busy;
        bus_rdata[ST_SREQ] = sreq;
      end
      A_IEN: begin
        bus_rdata[ST_TO]   = ien_q[0];
        bus_rdata[ST_OVR]  = ien_q[1];
        bus_rdata[ST_SREQ] = ien_q[2];
      end
      A_FIFO: if (!fifo_empty) begin
        bus_rdata[WORD_W-1:0] = fifo_rdata;
        bus_rdata[VLD_BIT]    = 1'b1;
      end
      default: ;
    endcase
  end

  assign irq = (tm_timeout & ien_q[0]) | (ovr_q & ien_q[1]) | (sreq & ien_q[2]);
endmodule

// File: rtl/irpw_checker.sv
module irpw_checker
  import irpw_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int FILL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FILL_W-1:0] fill,
  input logic              ovr,
  input logic              to,
  input logic              busy,
  input logic              fifo_en,
  input logic              rx_en,
  input logic              rd,
  input logic [REG_AW-1:0] addr,
  input logic              rd_valid
);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);

  p_ovr_from_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(fill) == FULL);

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && fifo_en) |=> ovr);

  p_to_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (to && rx_en) |=> to);

  p_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to) |-> !busy);

  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == A_FIFO && fill == '0) |-> !rd_valid);
endmodule

bind irpw_capture irpw_checker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .fill(fifo_fill), .ovr(ovr_q), .to(tm_timeout),
  .busy(tm_busy), .fifo_en(fifo_en), .rx_en(rx_en), .rd(bus_rd),
  .addr(bus_addr), .rd_valid(bus_rdata[17])
);

// File: tb/tb_irpw_capture.sv
module tb_irpw_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [2:0] RA_CTRL = 3'd0, RA_DIV = 3'd1, RA_FILT = 3'd2,
                         RA_STAT = 3'd3, RA_IEN = 3'd4, RA_FIFO = 3'd5;

  irpw_capture #(.PW_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctl(bit rx, bit fe, logic [1:0] edg, bit wm, bit nomark);
    return {26'd0, nomark, wm, edg, fe, rx};
  endfunction

  function automatic logic [31:0] word(bit lvl, int d, int r);
    return 32'h20000 | (32'(lvl) << 16) | 32'(((d - 1) / (r + 1)) >> 2);
  endfunction

  task automatic cfg(input logic [31:0] c, input int r, input int f, input logic [31:0] ie);
    wr(RA_CTRL, 32'd0);
    wr(RA_DIV, 32'(r));
    wr(RA_FILT, 32'(f));
    wr(RA_IEN, ie);
    wr(RA_CTRL, c);
    @(negedge clk);
  endtask

  task automatic setlvl(input bit v, input int n);
    ir_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(RA_CTRL, d); chk("R1 ctrl after reset", d, 0);
    rd(RA_STAT, d); chk("R1 status after reset", d, 0);
    rd(RA_IEN, d);  chk("R1 enables after reset", d, 0);
    rd(RA_FIFO, d); chk("R1 fifo read after reset", d, 0);
    chk("R1 irq after reset", 32'(irq), 0);
  endtask

  task automatic t_measure;
    logic [31:0] d;
    cfg(ctl(1, 1, 2'd3, 1, 0), 3, 0, 32'h10);
    setlvl(1, 200); setlvl(0, 120); setlvl(1, 64); setlvl(0, 20);
    rd(RA_STAT, d); chk("R3 R10 busy and not-empty request", d, 32'h14);
    chk("R12 irq from service request", 32'(irq), 1);
    rd(RA_FIFO, d); chk("R2 R3 first word mark 200", d, word(1, 200, 3));
    rd(RA_FIFO, d); chk("R2 second word space 120", d, word(0, 120, 3));
    rd(RA_FIFO, d); chk("R2 third word mark 64", d, word(1, 64, 3));
    rd(RA_FIFO, d); chk("R11 empty read invalid", d, 0);
    rd(RA_STAT, d); chk("R10 R11 request gone after drain", d, 32'h04);
    chk("R12 irq low after drain", 32'(irq), 0);
  endtask

  task automatic t_edge_none;
    logic [31:0] d;
    cfg(ctl(1, 1, 2'd0, 1, 0), 0, 0, 32'h0);
    setlvl(1, 30); setlvl(0, 30); setlvl(1, 30); setlvl(0, 30);
    rd(RA_STAT, d); chk("R4 no edges selected idle", d, 0);
  endtask

  task automatic t_edge_rise;
    logic [31:0] d;
    cfg(ctl(1, 1, 2'd2, 1, 0), 3, 0, 32'h0);
    setlvl(1, 100); setlvl(0, 60); setlvl(1, 40); setlvl(0, 20);
    rd(RA_FIFO, d); chk("R4 rising-only word", d, word(0, 160, 3));
    rd(RA_FIFO, d); chk("R4 falling edges ignored", d, 0);
  endtask

  task automatic t_filter;
    logic [31:0] d;
    cfg(ctl(1, 1, 2'd3, 1, 0), 3, 10, 32'h0);
    setlvl(1, 5); setlvl(0, 40);
    rd(RA_STAT, d); chk("R5 short pulse rejected", d, 0);
    @(negedge clk);
    setlvl(1, 80); setlvl(0, 30);
    rd(RA_FIFO, d); chk("R5 long pulse passes filter", d, word(1, 80, 3));
    rd(RA_FIFO, d); chk("R5 single word only", d, 0);
  endtask

  task automatic t_timeout;
    logic [31:0] d;
    cfg(ctl(1, 1, 2'd3, 1, 0), 0, 0, 32'h01);
    setlvl(1, 20); setlvl(0, 4400);
    rd(RA_STAT, d); chk("R6 timeout set busy clear", d, 32'h11);
    chk("R12 irq from timeout", 32'(irq), 1);
    rd(RA_FIFO, d); chk("R6 word before timeout", d, word(1, 20, 0));
    rd(RA_FIFO, d); chk("R6 marker word", d, 32'h3FFFF);
    rd(RA_FIFO, d); chk("R6 nothing after marker", d, 0);
    rd(RA_STAT, d); chk("R8 timeout held while enabled", d, 32'h01);
    wr(RA_CTRL, ctl(0, 1, 2'd3, 1, 0));
    wr(RA_CTRL, ctl(1, 1, 2'd3, 1, 0));
    rd(RA_STAT, d); chk("R8 timeout cleared by enable toggle", d, 0);
    chk("R12 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_suppress;
    logic [31:0] d;
    cfg(ctl(1, 1, 2'd3, 1, 1), 0, 0, 32'h0);
    setlvl(1, 20); setlvl(0, 4400);
    rd(RA_STAT, d); chk("R7 timeout without marker status", d, 32'h11);
    rd(RA_FIFO, d); chk("R7 measured word kept", d, word(1, 20, 0));
    rd(RA_FIFO, d); chk("R7 no marker word", d, 0);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    cfg(ctl(1, 1, 2'd3, 0, 0), 0, 0, 32'h10);
    for (int i = 0; i < 10; i++) begin
      setlvl((i % 2) == 0, 20);
      if (i == 3) chk("R10 three words below half", 32'(irq), 0);
      if (i == 4) chk("R10 four words reach half", 32'(irq), 1);
    end
    rd(RA_STAT, d); chk("R9 overrun set", d, 32'h16);
    wr(RA_IEN, 32'h02);
    chk("R12 irq from overrun", 32'(irq), 1);
    for (int k = 0; k < 8; k++) begin
      rd(RA_FIFO, d);
      chk("R9 stored word", d, word((k % 2) == 0, 20, 0));
    end
    rd(RA_FIFO, d); chk("R9 ninth push dropped", d, 0);
    rd(RA_STAT, d); chk("R9 overrun sticky after drain", d, 32'h06);
    wr(RA_CTRL, ctl(1, 0, 2'd3, 0, 0));
    wr(RA_CTRL, ctl(1, 1, 2'd3, 0, 0));
    rd(RA_STAT, d); chk("R9 overrun cleared by fifo enable toggle", d, 32'h04);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_measure();
    t_edge_none();
    t_edge_rise();
    t_filter();
    t_timeout();
    t_suppress();
    t_overrun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule